// File: doc/BRIEF.md
# Video Controller CPU Register Port

This block is the processor-facing side of a tile-based video controller. The CPU sees eight byte-wide registers. They occupy an 8-byte slot that repeats through the whole 0x2000–0x3FFF range. Behind them the block keeps a control byte, a mask byte, and a horizontal and a vertical scroll byte. It also keeps a 14-bit video memory pointer, which is loaded by two byte writes. Scroll and pointer loading share one first/second write toggle, and a status read resets that toggle.

The data register gives the CPU access to video memory. Reads below the palette area are delayed by one access: each read returns what the previous fetch left in a buffer, and then starts a fresh fetch. The fetch goes out on a memory request port. Palette entries live in a separate 32 x 6-bit RAM that the block reaches through its own port. Palette reads are answered at once, while the byte beneath the palette address still refills the buffer.

An 8-bit bus latch models the floating internal data bus. Reads of registers that cannot be read return whatever the latch holds.

Top module: `vid_regport`

## Requirements
- R1: A register is selected only by `cpu_addr[2:0]`, and only when `cpu_addr[15:13]` is 3'b001. Register indices are 0 control, 1 mask, 2 status, 3 and 4 sprite-side bytes (write-only here), 5 scroll, 6 pointer, 7 data. Strobes at any other address change nothing.
- R2: Writes to register 6 come in pairs. The first write takes bits [5:0] of the byte as pointer bits [13:8]; bits 7:6 are dropped, which folds the pointer into 14 bits. The second write loads bits [7:0] and commits the whole pointer to `vaddr`.
- R3: Writes to register 5 load `scroll_x` on the first write and `scroll_y` on the second. Registers 5 and 6 share one toggle, so a register-5 write followed by a register-6 write makes the register-6 write act as a second write.
- R4: A status read returns `{status_in[2:0], latch[4:0]}` and clears the shared toggle. It also raises `status_rd` for that strobe cycle.
- R5: Every data-register read or write advances `vaddr` by 1. When control bit 2 is set, it advances by 32 instead. The pointer wraps modulo 2^14.
- R6: A data read with `vaddr` below 0x3F00 returns the buffer. In the next cycle it issues a one-cycle `mem_rd` at the old pointer, and the buffer takes `mem_rdata` one cycle after that. CPU accesses are spaced at least 3 cycles apart.
- R7: A data read with `vaddr[13:8]` = 0x3F returns `{latch[7:6], pal_rdata}` straight away, with `pal_addr` = `vaddr[4:0]`. It still fetches the memory byte at that address into the buffer.
- R8: When mask bit 0 is set, palette read data is ANDed with 0x30. Palette writes store the full 6 bits whatever the mask holds.
- R9: A data write in the palette range pulses `pal_we` with `pal_wdata` = data[5:0] and produces no `mem_wr`. A data write elsewhere produces one `mem_wr` cycle with the old pointer and the byte. `mem_rd` and `mem_wr` never coincide.
- R10: Any register write loads the latch. Status and data reads load the latch with the value they return. Reads of registers 0, 1, 3, 4, 5 and 6 return the latch.
- R11: `cpu_rdata` is registered: it changes in the cycle after a read strobe and holds otherwise. After reset all registers, the pointer, the buffer and the latch are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | One-cycle read strobe |
| cpu_wr | input | 1 | One-cycle write strobe |
| cpu_rdata | output | 8 | Registered read data |
| status_in | input | 3 | Status flags from frame timing, returned in bits 7:5 |
| status_rd | output | 1 | High during a status read strobe |
| ctrl_q | output | 8 | Control register |
| mask_q | output | 8 | Mask register |
| scroll_x | output | 8 | Horizontal scroll |
| scroll_y | output | 8 | Vertical scroll |
| vaddr | output | 14 | Video memory pointer |
| mem_addr | output | 14 | Memory request address |
| mem_wdata | output | 8 | Memory write data |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| mem_rdata | input | 8 | Memory read data, valid the cycle after `mem_rd` |
| pal_addr | output | 5 | Palette entry index |
| pal_wdata | output | 6 | Palette write data |
| pal_we | output | 1 | Palette write enable |
| pal_rdata | input | 6 | Palette read data, combinational |

## Verification
The bench targets places where this port can misbehave.

- **Status read in the middle of a pointer pair.** If it failed to reset the toggle, the next byte would become the low half and the pointer would go wrong.
- **Scroll write followed by a pointer write.** If each register kept its own toggle, that pointer write would load the high half instead of the low half.
- **Buffered read sequence.** A missing delay would return the current byte, not the previous one.
- **Read straddling the palette boundary.** A design that skipped the underlying fetch would return the stale buffer on the next non-palette read.
- **Palette reads under greyscale.** A design that masked on write would leave the stored entry changed.
- **Open-bus bits.** A design that did not feed the latch would show zero or stale bits in the unused fields.
- **Step of 32 and pointer wrap past 0x3FFF.** Both are exercised so that increment and folding errors show up in `vaddr`.

// File: rtl/vid_regport.sv
module vid_regport #(
  parameter int VA_W  = 14,
  parameter int PAL_W = 6,
  parameter int PAL_N = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  output logic [7:0]        cpu_rdata,
  input  logic [2:0]        status_in,
  output logic              status_rd,
  output logic [7:0]        ctrl_q,
  output logic [7:0]        mask_q,
  output logic [7:0]        scroll_x,
  output logic [7:0]        scroll_y,
  output logic [VA_W-1:0]   vaddr,
  output logic [VA_W-1:0]   mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              mem_rd,
  output logic              mem_wr,
  input  logic [7:0]        mem_rdata,
  output logic [$clog2(PAL_N)-1:0] pal_addr,
  output logic [PAL_W-1:0]  pal_wdata,
  output logic              pal_we,
  input  logic [PAL_W-1:0]  pal_rdata
);
  localparam int PA_W = $clog2(PAL_N);
  localparam int HI_W = VA_W - 8;

  localparam logic [2:0] R_CTRL = 3'd0, R_MASK = 3'd1, R_STAT = 3'd2,
                         R_SCRL = 3'd5, R_PTR  = 3'd6, R_DATA = 3'd7;

  logic [7:0]      latch_q, rbuf_q;
  logic [HI_W-1:0] hi_q;
  logic            tog_q, fetch_q;

  logic            sel, rd_s, wr_s, is_pal, data_acc;
  logic [2:0]      rsel;
  logic [VA_W-1:0] step;
  logic [PAL_W-1:0] pal_val;
  logic [7:0]      rd_val;

  assign sel      = cpu_addr[15:13] == 3'b001;
  assign rsel     = cpu_addr[2:0];
  assign rd_s     = cpu_rd & sel;
  assign wr_s     = cpu_wr & ~cpu_rd & sel;
  assign is_pal   = vaddr[VA_W-1:8] == {HI_W{1'b1}} - HI_W'(6'h00) && vaddr[VA_W-1:8] == HI_W'(6'h3F);
  assign data_acc = (rd_s | wr_s) && rsel == R_DATA;
  assign step     = ctrl_q[2] ? VA_W'(32) : VA_W'(1);
  assign pal_val  = pal_rdata & (mask_q[0] ? PAL_W'(6'h30) : {PAL_W{1'b1}});

  assign status_rd = rd_s && rsel == R_STAT;
  assign pal_addr  = vaddr[PA_W-1:0];
  assign pal_wdata = cpu_wdata[PAL_W-1:0];
  assign pal_we    = wr_s && rsel == R_DATA && is_pal;

  always_comb begin
    case (rsel)
      R_STAT:  rd_val = {status_in, latch_q[4:0]};
      R_DATA:  rd_val = is_pal ? {latch_q[7:PAL_W], pal_val} : rbuf_q;
      default: rd_val = latch_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpu_rdata <= '0;
      ctrl_q    <= '0;
      mask_q    <= '0;
      scroll_x  <= '0;
      scroll_y  <= '0;
      vaddr     <= '0;
      hi_q      <= '0;
      tog_q     <= 1'b0;
      latch_q   <= '0;
      rbuf_q    <= '0;
      fetch_q   <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_rd    <= 1'b0;
      mem_wr    <= 1'b0;
    end else begin
      mem_rd  <= 1'b0;
      mem_wr  <= 1'b0;
      fetch_q <= mem_rd;
      if (fetch_q) rbuf_q <= mem_rdata;

      if (wr_s) begin
        latch_q <= cpu_wdata;
        case (rsel)
          R_CTRL: ctrl_q <= cpu_wdata;
          R_MASK: mask_q <= cpu_wdata;
          R_SCRL: begin
            if (tog_q) scroll_y <= cpu_wdata;
            else       scroll_x <= cpu_wdata;
            tog_q <= ~tog_q;
          end
          R_PTR: begin
            if (tog_q) vaddr <= {hi_q, cpu_wdata};
            else       hi_q  <= cpu_wdata[HI_W-1:0];
            tog_q <= ~tog_q;
          end
          R_DATA: begin
            if (!is_pal) begin
              mem_wr    <= 1'b1;
              mem_addr  <= vaddr;
              mem_wdata <= cpu_wdata;
            end
          end
          default: ;
        endcase
      end

      if (rd_s) begin
        cpu_rdata <= rd_val;
        if (rsel == R_STAT) begin
          latch_q <= rd_val;
          tog_q   <= 1'b0;
        end
        if (rsel == R_DATA) begin
          latch_q  <= rd_val;
          mem_rd   <= 1'b1;
          mem_addr <= vaddr;
        end
      end

      if (data_acc) vaddr <= vaddr + step;
    end
  end
endmodule

// File: rtl/vid_regport_chk.sv
module vid_regport_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] cpu_addr,
  input logic        cpu_rd,
  input logic        cpu_wr,
  input logic [7:0]  cpu_rdata,
  input logic [7:0]  ctrl_q,
  input logic [7:0]  mask_q,
  input logic [13:0] vaddr,
  input logic [13:0] mem_addr,
  input logic        mem_rd,
  input logic        mem_wr,
  input logic        tog_q
);
  logic in_win, dacc, drd;
  assign in_win = cpu_addr[15:13] == 3'b001;
  assign dacc   = in_win && (cpu_rd || cpu_wr) && cpu_addr[2:0] == 3'd7;
  assign drd    = in_win && cpu_rd && cpu_addr[2:0] == 3'd7;

  assert_toggle_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_win && cpu_rd && cpu_addr[2:0] == 3'd2) |=> !tog_q);

  assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dacc |=> vaddr == 14'($past(vaddr) + ($past(ctrl_q[2]) ? 14'd32 : 14'd1)));

  assert_fetch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (drd && vaddr[13:8] != 6'h3F) |=> (mem_rd && mem_addr == $past(vaddr)));

  assert_grey_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (drd && vaddr[13:8] == 6'h3F && mask_q[0]) |=> cpu_rdata[3:0] == 4'h0);

  assert_no_overlap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  assert_wr_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> !mem_wr);
endmodule

bind vid_regport vid_regport_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
  .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata), .ctrl_q(ctrl_q), .mask_q(mask_q),
  .vaddr(vaddr), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .tog_q(tog_q)
);

// File: tb/vid_regport_test.sv
module vid_regport_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0, cpu_rdata;
  logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [2:0]  status_in = 3'b101;
  logic        status_rd;
  logic [7:0]  ctrl_q, mask_q, scroll_x, scroll_y;
  logic [13:0] vaddr, mem_addr;
  logic [7:0]  mem_wdata, mem_rdata = '0;
  logic        mem_rd, mem_wr, pal_we;
  logic [4:0]  pal_addr;
  logic [5:0]  pal_wdata, pal_rdata;
  logic [5:0]  pal_mem [0:31];

  int n_chk = 0, n_fail = 0, n_mwr = 0, n_srd = 0;
  logic [13:0] last_rd_addr = '0, last_wr_addr = '0;
  logic [7:0]  last_wr_data = '0;
  logic [7:0]  exp_q[$];
  string       tag_q[$];

  vid_regport uut (.*);

  always #5 clk = ~clk;

  function automatic logic [7:0] fm(input logic [13:0] a);
    return a[7:0] ^ {2'b00, a[13:8]} ^ 8'h5A;
  endfunction

  assign pal_rdata = pal_mem[pal_addr];
  always @(posedge clk) begin
    if (pal_we) pal_mem[pal_addr] <= pal_wdata;
    if (mem_rd) begin mem_rdata <= fm(mem_addr); last_rd_addr <= mem_addr; end
    if (mem_wr) begin n_mwr <= n_mwr + 1; last_wr_addr <= mem_addr; last_wr_data <= mem_wdata; end
    if (status_rd) n_srd <= n_srd + 1;
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk); cpu_wr = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic rd(input logic [15:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); cpu_addr = a; cpu_rd = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); cpu_rd = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (cpu_rd && rst_n) begin
        @(negedge clk);
        if (exp_q.size() == 0) chk(1, 0, "scoreboard underflow");
        else chk(cpu_rdata, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(20000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 32; i++) pal_mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ctrl_q, 0, "R11 reset ctrl");
    chk(vaddr, 0, "R11 reset pointer");
    chk(cpu_rdata, 0, "R11 reset rdata");

    wr(16'h3456, 8'h21); wr(16'h2006, 8'h08);
    chk(vaddr, 14'h2108, "R1 R2 mirrored pointer pair");
    wr(16'h4006, 8'h55);
    chk(vaddr, 14'h2108, "R1 outside window ignored");
    rd(16'h2000, 8'h08, "R10 R1 write-only read returns latch");

    wr(16'h2006, 8'hE1); wr(16'h2006, 8'h23);
    chk(vaddr, 14'h2123, "R2 high bits folded");

    wr(16'h2006, 8'h12);
    rd(16'h2002, 8'hB2, "R4 status byte");
    chk(n_srd, 1, "R4 status_rd pulse count");
    wr(16'h2006, 8'h05); wr(16'h2006, 8'h40);
    chk(vaddr, 14'h0540, "R4 toggle cleared by status read");

    rd(16'h2007, 8'hB2 & 8'h00, "R6 first read returns empty buffer");
    rd(16'h2007, fm(14'h0540), "R6 buffered byte");
    rd(16'h2007, fm(14'h0541), "R6 buffered byte next");
    chk(vaddr, 14'h0543, "R5 step of one");
    chk(last_rd_addr, 14'h0542, "R6 fetch address");

    wr(16'h2000, 8'h04); wr(16'h2006, 8'h10); wr(16'h2006, 8'h00);
    rd(16'h2007, fm(14'h0542), "R6 buffer across pointer reload");
    rd(16'h2007, fm(14'h1000), "R6 R5 read with step 32");
    chk(vaddr, 14'h1040, "R5 step of 32");

    wr(16'h2006, 8'h3F); wr(16'h2006, 8'hF0); wr(16'h2007, 8'h01);
    chk(vaddr, 14'h0010, "R5 pointer wraps");
    chk(pal_mem[16], 6'h01, "R9 palette write at wrap");
    wr(16'h2000, 8'h00);

    wr(16'h2006, 8'h3F); wr(16'h2006, 8'h05);
    begin
      int mw0 = n_mwr;
      wr(16'h2007, 8'hFF); wr(16'h2007, 8'h2A);
      chk(n_mwr, mw0, "R9 palette write avoids memory");
    end
    chk(pal_mem[5], 6'h3F, "R9 palette entry 5");
    chk(pal_mem[6], 6'h2A, "R9 palette entry 6");

    wr(16'h2006, 8'h3F); wr(16'h2006, 8'h05);
    wr(16'h2003, 8'hC0);
    rd(16'h2007, 8'hFF, "R7 immediate palette read with latch bits");
    wr(16'h2001, 8'h01);
    rd(16'h2007, 8'h20, "R8 greyscale palette read");
    wr(16'h2007, 8'h1B);
    chk(pal_mem[7], 6'h1B, "R8 palette write unaffected by greyscale");
    wr(16'h2001, 8'h00);
    wr(16'h2006, 8'h00); wr(16'h2006, 8'h10);
    rd(16'h2007, fm(14'h3F06), "R7 underlying byte buffered");
    rd(16'h2005, fm(14'h3F06), "R10 data read fills latch");

    wr(16'h2006, 8'h01); wr(16'h2006, 8'h23);
    begin
      int mw1 = n_mwr;
      wr(16'h2007, 8'h77);
      chk(n_mwr, mw1 + 1, "R9 one memory write");
    end
    chk(last_wr_addr, 14'h0123, "R9 memory write address");
    chk(last_wr_data, 8'h77, "R9 memory write data");
    chk(vaddr, 14'h0124, "R5 step after write");

    wr(16'h2005, 8'h11); wr(16'h2005, 8'h22);
    chk(scroll_x, 8'h11, "R3 scroll x");
    chk(scroll_y, 8'h22, "R3 scroll y");
    wr(16'h2005, 8'h33); wr(16'h2006, 8'h1A);
    chk(scroll_x, 8'h33, "R3 scroll x rewrite");
    chk(vaddr, 14'h011A, "R3 shared toggle");
    wr(16'h2006, 8'h1B); wr(16'h2006, 8'h2C);
    chk(vaddr, 14'h1B2C, "R3 toggle back to first");

    repeat (4) @(negedge clk);
    chk(exp_q.size(), 0, "R11 all reads observed");
    finish_run();
  end
endmodule